// File: doc/BRIEF.md
# PCI Target Transaction Sequencer

This block is the target-side bus sequencer of a PCI slave. It watches the framing signal and the 64-bit request line. In the first clock of a cycle it captures the address and the command. It then classifies the command as memory, I/O or configuration, and compares the address against six programmable base ranges. If the cycle is accepted, it claims the cycle with the device-select line using slow decode timing. For 64-bit memory requests it also raises the 64-bit acknowledge. It then runs the data phases with the target-ready and stop lines.

On the local side, the block presents a one-hot range hit, a normalised command, a strobe for each local word moved, and a flag that tells which half of the word is on a 32-bit bus. Four request inputs steer the data phases: ready, retry, disconnect and abort. The base, mask, enable and I/O-space settings of each range come from the configuration-space logic, which sits outside the block. All active-low bus controls leave the block as values plus one shared output enable. Read data leaves as a 64-bit value plus its own enable.

Top module: `pts_target_seq`

## Requirements
- R1: The address and command are captured in the clock in which FRAME# is first sampled low while the block is idle. Later changes of the AD lines do not alter the decode. `cmd_out` reports commands 0xC and 0xE as 0x6, reports 0xF as 0x7, and passes every other command through unchanged.
- R2: DEVSEL# goes low in the third clock after the address clock. It is still high in the second clock. A cycle whose address hits no enabled range of the matching space is never claimed.
- R3: When FRAME# falls with REQ64# low, a memory command asserts ACK64# in the same clock as DEVSEL#. ACK64# is never low while DEVSEL# is high. I/O and configuration commands never assert ACK64#.
- R4: `bar_hit` is one-hot, or zero, while the cycle is claimed. A range matches when `((addr ^ base) & mask) == 0`, its enable bit is set, and its I/O bit equals "the command is I/O". If several ranges match, the lowest index wins. Configuration cycles show zero.
- R5: A configuration command (0xA or 0xB) is claimed only when IDSEL is high and AD[1:0] = 00. It asserts TRDY# in its first data phase whatever the state of the local ready, retry and abort inputs.
- R6: An I/O command (0x2 or 0x3) is a single data phase. The local disconnect request has no effect on it. Retry and abort are honoured.
- R7: In a memory data phase with no termination request, TRDY# follows local ready. A burst moves one word per clock while ready stays high, and it waits while ready is low.
- R8: Retry drives STOP# low with TRDY# high. Disconnect drives STOP# low, with TRDY# low when local ready is high. Abort drives DEVSEL# high and STOP# low. Abort outranks retry, and retry outranks disconnect. After STOP#, STOP# is held low with TRDY# high until FRAME# is sampled high.
- R9: A memory read without a 64-bit acknowledge drives the 64-bit local word onto AD[31:0] as two DWORDs. The lower DWORD comes first when address bit 2 is 0; the upper DWORD comes first when it is 1. `lcl_xfer` pulses only on the phase that moves the upper DWORD. With ACK64# low, every phase pulses `lcl_xfer` and carries the whole word.
- R10: After the last phase, DEVSEL#, TRDY#, STOP# and ACK64# are driven high for exactly one clock with `ctl_oe` high, and then released. While `ctl_oe` is low, all four lines read high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Cycle framing from the master |
| req64_n | input | 1 | 64-bit request from the master |
| irdy_n | input | 1 | Master ready |
| idsel | input | 1 | Configuration select |
| ad_in | input | 32 | Address/data lanes 31..0 as seen on the bus |
| cbe_in | input | 4 | Command / byte enables 3..0 |
| bar_base | input | 192 | Six 32-bit range bases, range 0 in the low bits |
| bar_mask | input | 192 | Six 32-bit compare masks |
| bar_en | input | 6 | Range enables |
| bar_io | input | 6 | Range lies in I/O space |
| lcl_ready | input | 1 | Local side ready for a data phase |
| lcl_retry | input | 1 | Local retry request |
| lcl_disc | input | 1 | Local disconnect request |
| lcl_abort | input | 1 | Local target-abort request |
| lcl_rdata | input | 64 | Local read word |
| devsel_n | output | 1 | Device select value |
| trdy_n | output | 1 | Target ready value |
| stop_n | output | 1 | Stop value |
| ack64_n | output | 1 | 64-bit acknowledge value |
| ctl_oe | output | 1 | Drive enable for the four control lines |
| ad_out | output | 64 | Read data to the AD lanes |
| ad_oe | output | 1 | Drive enable for read data |
| bar_hit | output | 6 | One-hot range hit of the claimed cycle |
| cmd_out | output | 4 | Normalised command |
| lcl_xfer | output | 1 | A local word moved this clock |
| lcl_hi | output | 1 | Upper DWORD of the word is on the narrow bus |

## Verification
The assertions check on every clock the rules that hold in any state. The claim edge of DEVSEL# must trail the address clock by exactly three cycles. ACK64# must never appear without DEVSEL#. The range hit must stay one-hot. An abort must never show TRDY#, and the control lines must be high whenever they are released. Three rules also hold on every clock: a configuration phase ignores the local side, an I/O phase ignores disconnect, and the lines are high in the clock before release. The bench scenarios show the other rules. These are the decode result for each mix of command, space and overlapping ranges, the command aliases, the order of DWORDs on a narrow read, and the exact length of the stop-hold and turnaround windows.

// File: rtl/pts_pkg.sv
package pts_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEC1, ST_DEC2, ST_DATA, ST_STOPW, ST_TURN, ST_SKIP
  } pts_state_e;

  typedef enum logic [1:0] {CL_NONE, CL_MEM, CL_IO, CL_CFG} pts_class_e;

  // Command space of a bus command code.
  function automatic pts_class_e cmd_class(input logic [3:0] c);
    case (c)
      4'h2, 4'h3:                    return CL_IO;
      4'h6, 4'h7, 4'hC, 4'hE, 4'hF:  return CL_MEM;
      4'hA, 4'hB:                    return CL_CFG;
      default:                       return CL_NONE;
    endcase
  endfunction

  // Read-line/read-multiple fold into read, write-invalidate into write.
  function automatic logic [3:0] norm_cmd(input logic [3:0] c);
    case (c)
      4'hC, 4'hE: return 4'h6;
      4'hF:       return 4'h7;
      default:    return c;
    endcase
  endfunction

  // Every supported read command has bit 0 clear.
  function automatic logic cmd_is_read(input logic [3:0] c);
    return ~c[0];
  endfunction

endpackage

// File: rtl/pts_decode.sv
module pts_decode
  import pts_pkg::*;
#(
  parameter int NBAR = 6,
  parameter int AW   = 32
) (
  input  logic [AW-1:0]      addr,
  input  logic [3:0]         cmd,
  input  logic               idsel,
  input  logic [NBAR*AW-1:0] base,
  input  logic [NBAR*AW-1:0] mask,
  input  logic [NBAR-1:0]    en,
  input  logic [NBAR-1:0]    io,
  output logic [NBAR-1:0]    hit,
  output pts_class_e         cls,
  output logic               claim
);

  localparam logic [NBAR-1:0] LSB_ONE = {{(NBAR-1){1'b0}}, 1'b1};

  logic [NBAR-1:0] raw;
  logic            is_io;
  logic            spaced;

  assign cls    = cmd_class(cmd);
  assign is_io  = (cls == CL_IO);
  assign spaced = (cls == CL_MEM) || is_io;

  for (genvar g = 0; g < NBAR; g++) begin : g_range
    assign raw[g] = en[g] && spaced && (io[g] == is_io) &&
                    (((addr ^ base[g*AW +: AW]) & mask[g*AW +: AW]) == '0);
  end

  // Isolate the lowest set bit: lowest index has priority.
  assign hit   = raw & (~raw + LSB_ONE);
  assign claim = (cls == CL_CFG) ? (idsel && (addr[1:0] == 2'b00)) : (|raw);

endmodule

// File: rtl/pts_ctl.sv
module pts_ctl
  import pts_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_n,
  input  logic       irdy_n,
  input  logic       addr_evt,
  input  logic       claim_in,
  input  pts_class_e cls_in,
  input  logic       wide_in,
  input  logic       lcl_ready,
  input  logic       lcl_retry,
  input  logic       lcl_disc,
  input  logic       lcl_abort,
  output logic       devsel_n,
  output logic       trdy_n,
  output logic       stop_n,
  output logic       ack64_n,
  output logic       ctl_oe,
  output logic       idle,
  output logic       in_data,
  output logic       xfer,
  output pts_class_e cls_q,
  output logic       wide_q
);

  pts_state_e st, st_nx;
  logic claim_q, abort_q;
  logic is_cfg, is_mem, abort_c, retry_c, disc_c, rdy_c, trdy_on, stop_on;

  // Data-phase decisions, priority abort > retry > disconnect.
  assign is_cfg  = (cls_q == CL_CFG);
  assign is_mem  = (cls_q == CL_MEM);
  assign abort_c = !is_cfg && lcl_abort;
  assign retry_c = !is_cfg && !abort_c && lcl_retry;
  assign disc_c  = is_mem && !abort_c && !retry_c && lcl_disc;
  assign rdy_c   = is_cfg || lcl_ready;
  assign trdy_on = !abort_c && !retry_c && rdy_c;
  // Single-phase spaces end a burst attempt by themselves.
  assign stop_on = abort_c || retry_c || disc_c || (!is_mem && !frame_n && rdy_c);

  assign idle    = (st == ST_IDLE);
  assign in_data = (st == ST_DATA);
  assign xfer    = in_data && trdy_on && !irdy_n;
  assign ctl_oe  = (st == ST_DATA) || (st == ST_STOPW) || (st == ST_TURN);

  always_comb begin
    devsel_n = 1'b1;
    trdy_n   = 1'b1;
    stop_n   = 1'b1;
    ack64_n  = 1'b1;
    case (st)
      ST_DATA: begin
        devsel_n = abort_c;
        ack64_n  = ~(wide_q & ~abort_c);
        trdy_n   = ~trdy_on;
        stop_n   = ~stop_on;
      end
      ST_STOPW: begin
        devsel_n = abort_q;
        ack64_n  = ~(wide_q & ~abort_q);
        stop_n   = 1'b0;
      end
      default: ;
    endcase
  end

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:  if (addr_evt) st_nx = ST_DEC1;
      ST_DEC1:  st_nx = ST_DEC2;
      ST_DEC2:  st_nx = claim_q ? ST_DATA : ST_SKIP;
      ST_DATA: begin
        if (stop_on) begin
          if (!(trdy_on && irdy_n)) st_nx = ST_STOPW;
        end else if (xfer && frame_n) begin
          st_nx = ST_TURN;
        end
      end
      ST_STOPW: if (frame_n) st_nx = ST_TURN;
      ST_TURN:  st_nx = ST_IDLE;
      ST_SKIP:  if (frame_n && irdy_n) st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      claim_q <= 1'b0;
      abort_q <= 1'b0;
      cls_q   <= CL_NONE;
      wide_q  <= 1'b0;
    end else begin
      st <= st_nx;
      if (idle && addr_evt) begin
        claim_q <= claim_in;
        cls_q   <= cls_in;
        wide_q  <= wide_in;
        abort_q <= 1'b0;
      end
      if (in_data && st_nx == ST_STOPW) abort_q <= abort_c;
    end
  end

  // R5: a configuration phase never waits on or is stopped by the local side.
  assert_cfg_local_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && is_cfg && frame_n) |-> (!trdy_n && stop_n && !devsel_n))
    else $error("configuration phase depended on local inputs");

  // R6: disconnect never stops a single I/O phase.
  assert_io_no_disc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && cls_q == CL_IO && frame_n && !lcl_retry && !lcl_abort) |-> stop_n)
    else $error("I/O phase stopped without retry or abort");

  // R8: abort never carries data.
  assert_abort_no_trdy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n && devsel_n) |-> trdy_n)
    else $error("TRDY# seen during target abort");

endmodule

// File: rtl/pts_lanes.sv
module pts_lanes
  import pts_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_hi,
  input  logic          start_rd,
  input  pts_class_e    cls,
  input  logic          wide,
  input  logic          in_data,
  input  logic          xfer,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic          lcl_xfer,
  output logic          lcl_hi
);

  localparam int HW = DW / 2;

  logic read_q, half_q, narrow;

  assign narrow   = read_q && (cls == CL_MEM) && !wide;
  assign lcl_hi   = narrow && half_q;
  assign lcl_xfer = xfer && (!narrow || half_q);
  assign ad_oe    = in_data && read_q;
  assign ad_out   = {rdata[DW-1:HW], lcl_hi ? rdata[DW-1:HW] : rdata[HW-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      read_q <= 1'b0;
      half_q <= 1'b0;
    end else if (start) begin
      read_q <= start_rd;
      half_q <= start_hi;
    end else if (xfer && narrow) begin
      half_q <= ~half_q;
    end
  end

endmodule

// File: rtl/pts_target_seq.sv
module pts_target_seq
  import pts_pkg::*;
#(
  parameter int NBAR = 6,
  parameter int AW   = 32,
  parameter int DW   = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_n,
  input  logic               req64_n,
  input  logic               irdy_n,
  input  logic               idsel,
  input  logic [AW-1:0]      ad_in,
  input  logic [3:0]         cbe_in,
  input  logic [NBAR*AW-1:0] bar_base,
  input  logic [NBAR*AW-1:0] bar_mask,
  input  logic [NBAR-1:0]    bar_en,
  input  logic [NBAR-1:0]    bar_io,
  input  logic               lcl_ready,
  input  logic               lcl_retry,
  input  logic               lcl_disc,
  input  logic               lcl_abort,
  input  logic [DW-1:0]      lcl_rdata,
  output logic               devsel_n,
  output logic               trdy_n,
  output logic               stop_n,
  output logic               ack64_n,
  output logic               ctl_oe,
  output logic [DW-1:0]      ad_out,
  output logic               ad_oe,
  output logic [NBAR-1:0]    bar_hit,
  output logic [3:0]         cmd_out,
  output logic               lcl_xfer,
  output logic               lcl_hi
);

  logic            frame_q, idle, addr_evt, in_data, xfer, wide_q, dec_claim;
  logic [NBAR-1:0] dec_hit, hit_q;
  logic [3:0]      cmd_q;
  pts_class_e      dec_cls, cls_q;

  // Address clock: first low FRAME# seen while idle.
  assign addr_evt = idle && !frame_n && frame_q;

  pts_decode #(.NBAR(NBAR), .AW(AW)) decode_i (
    .addr(ad_in), .cmd(cbe_in), .idsel(idsel), .base(bar_base), .mask(bar_mask),
    .en(bar_en), .io(bar_io), .hit(dec_hit), .cls(dec_cls), .claim(dec_claim)
  );

  pts_ctl ctl_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .addr_evt(addr_evt), .claim_in(dec_claim), .cls_in(dec_cls),
    .wide_in(!req64_n && dec_cls == CL_MEM),
    .lcl_ready(lcl_ready), .lcl_retry(lcl_retry), .lcl_disc(lcl_disc), .lcl_abort(lcl_abort),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .ack64_n(ack64_n),
    .ctl_oe(ctl_oe), .idle(idle), .in_data(in_data), .xfer(xfer),
    .cls_q(cls_q), .wide_q(wide_q)
  );

  pts_lanes #(.DW(DW)) lanes_i (
    .clk(clk), .rst_n(rst_n), .start(addr_evt), .start_hi(ad_in[2]),
    .start_rd(cmd_is_read(cbe_in)), .cls(cls_q), .wide(wide_q), .in_data(in_data),
    .xfer(xfer), .rdata(lcl_rdata), .ad_out(ad_out), .ad_oe(ad_oe),
    .lcl_xfer(lcl_xfer), .lcl_hi(lcl_hi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= 1'b1;
      hit_q   <= '0;
      cmd_q   <= '0;
    end else begin
      frame_q <= frame_n;
      if (addr_evt) begin
        hit_q <= dec_hit;
        cmd_q <= norm_cmd(cbe_in);
      end
    end
  end

  assign bar_hit = ctl_oe ? hit_q : '0;
  assign cmd_out = cmd_q;

  // R2: the claim edge trails the address clock by exactly three clocks.
  assert_slow_claim_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> $past(addr_evt, 3))
    else $error("DEVSEL# asserted off the slow-decode slot");

  // R3: 64-bit acknowledge only together with device select.
  assert_ack_needs_devsel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ack64_n |-> !devsel_n)
    else $error("ACK64# without DEVSEL#");

  // R4: at most one range reported.
  assert_hit_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bar_hit))
    else $error("range hit not one-hot");

  // R10: released lines read inactive.
  assert_release_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_oe |-> (devsel_n && trdy_n && stop_n && ack64_n))
    else $error("control line active while released");

  // R10: the lines are driven high in the clock before release.
  assert_turnaround_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_oe) |-> $past(devsel_n && trdy_n && stop_n && ack64_n))
    else $error("no high turnaround before release");

endmodule

// File: tb/pts_target_seq_tb.sv
`timescale 1ns/1ps
module pts_target_seq_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         frame_n = 1'b1, req64_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0;
  logic [31:0]  ad_in = '0;
  logic [3:0]   cbe_in = '0;
  logic [191:0] bar_base, bar_mask;
  logic [5:0]   bar_en, bar_io;
  logic         lcl_ready = 1'b0, lcl_retry = 1'b0, lcl_disc = 1'b0, lcl_abort = 1'b0;
  logic [63:0]  lcl_rdata = 64'hAAAA_BBBB_CCCC_DDDD;
  logic         devsel_n, trdy_n, stop_n, ack64_n, ctl_oe, ad_oe, lcl_xfer, lcl_hi;
  logic [63:0]  ad_out;
  logic [5:0]   bar_hit;
  logic [3:0]   cmd_out;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  pts_target_seq dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .req64_n(req64_n), .irdy_n(irdy_n),
    .idsel(idsel), .ad_in(ad_in), .cbe_in(cbe_in), .bar_base(bar_base), .bar_mask(bar_mask),
    .bar_en(bar_en), .bar_io(bar_io), .lcl_ready(lcl_ready), .lcl_retry(lcl_retry),
    .lcl_disc(lcl_disc), .lcl_abort(lcl_abort), .lcl_rdata(lcl_rdata),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .ack64_n(ack64_n),
    .ctl_oe(ctl_oe), .ad_out(ad_out), .ad_oe(ad_oe), .bar_hit(bar_hit),
    .cmd_out(cmd_out), .lcl_xfer(lcl_xfer), .lcl_hi(lcl_hi)
  );

  typedef struct packed {
    logic [3:0]  cmd;
    logic [31:0] addr;
    logic        sel, r64, burst, rdy, rty, dsc, abt;
    logic        e_dev, e_ack, e_trdy, e_stop;
    logic [5:0]  e_hit;
    logic [3:0]  e_cmd;
  } vec_t;

  localparam int NV = 12;
  // Expected values seen in the first data phase (third clock after address).
  localparam vec_t VEC [NV] = '{
    '{4'h6, 32'h1000_0040, 0,0,0, 1,0,0,0, 0,1,0,1, 6'b000001, 4'h6}, // R7 R2 single read
    '{4'h7, 32'h2004_0000, 0,1,1, 1,0,0,0, 0,0,0,1, 6'b000010, 4'h7}, // R3 64-bit write
    '{4'h2, 32'h0000_3004, 0,1,0, 1,0,1,0, 0,1,0,1, 6'b000100, 4'h2}, // R6 disc ignored, no ack
    '{4'h3, 32'h0000_6010, 0,0,0, 1,1,0,0, 0,1,1,0, 6'b100000, 4'h3}, // R8 I/O retry
    '{4'hA, 32'h0000_0010, 1,0,0, 0,0,0,1, 0,1,0,1, 6'b000000, 4'hA}, // R5 cfg ignores local
    '{4'h6, 32'h4000_0000, 0,0,0, 1,0,0,0, 1,1,1,1, 6'b000000, 4'h6}, // R2 disabled range
    '{4'hE, 32'h1000_0100, 0,0,1, 1,0,1,0, 0,1,0,0, 6'b000001, 4'h6}, // R1 R8 disconnect w/ data
    '{4'hF, 32'h1000_2000, 0,1,1, 1,0,0,1, 1,1,1,0, 6'b000001, 4'h7}, // R1 R8 abort
    '{4'hC, 32'h2000_8000, 0,0,0, 0,0,0,0, 0,1,1,1, 6'b000010, 4'h6}, // R7 wait state
    '{4'h2, 32'h1000_0000, 0,0,0, 1,0,0,0, 1,1,1,1, 6'b000000, 4'h2}, // R4 wrong space
    '{4'h6, 32'h2000_0800, 0,0,0, 1,0,0,0, 0,1,0,1, 6'b000010, 4'h6}, // R4 overlap priority
    '{4'hB, 32'h0000_0010, 0,0,0, 1,0,0,0, 1,1,1,1, 6'b000000, 4'hB}  // R5 no IDSEL
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic addr_phase(input logic [3:0] c, input logic [31:0] a, input logic s, input logic w);
    @(negedge clk);
    frame_n = 1'b0; req64_n = ~w; ad_in = a; cbe_in = c; idsel = s; irdy_n = 1'b1;
  endtask

  task automatic first_data(input logic burst, input logic w);
    @(negedge clk);
    frame_n = ~burst; req64_n = burst ? ~w : 1'b1; irdy_n = 1'b0;
    cbe_in = 4'h0; idsel = 1'b0; ad_in = 32'hDEAD_BEEF;
  endtask

  task automatic finish_txn();
    frame_n = 1'b1; req64_n = 1'b1;
    for (int k = 0; k < 20 && ctl_oe; k++) @(negedge clk);
    if (ctl_oe) chk("R10 cycle did not end", 64'(ctl_oe), 64'd0);
    irdy_n = 1'b1; lcl_ready = 1'b0; lcl_retry = 1'b0; lcl_disc = 1'b0; lcl_abort = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    bar_base = {32'h0000_6000, 32'h2000_0000, 32'h4000_0000, 32'h0000_3000, 32'h2000_0000, 32'h1000_0000};
    bar_mask = {32'hFFFF_FF00, 32'hFFFF_F000, 32'hFFFF_0000, 32'hFFFF_FF00, 32'hFFF0_0000, 32'hFFFF_0000};
    bar_en   = 6'b110111;
    bar_io   = 6'b100100;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state: everything released and inactive (R10).
    chk("R10 reset ctl", {devsel_n, trdy_n, stop_n, ack64_n, ctl_oe, ad_oe, lcl_xfer}, 64'b1111000);
    chk("R4 reset hit", 64'(bar_hit), 64'd0);

    for (int i = 0; i < NV; i++) begin
      addr_phase(VEC[i].cmd, VEC[i].addr, VEC[i].sel, VEC[i].r64);
      first_data(VEC[i].burst, VEC[i].r64);
      lcl_ready = VEC[i].rdy; lcl_retry = VEC[i].rty; lcl_disc = VEC[i].dsc; lcl_abort = VEC[i].abt;
      @(negedge clk); @(negedge clk);
      chk($sformatf("R2 vec%0d devsel", i), 64'(devsel_n), 64'(VEC[i].e_dev));
      chk($sformatf("R3 vec%0d ack64", i),  64'(ack64_n),  64'(VEC[i].e_ack));
      chk($sformatf("R8 vec%0d trdy", i),   64'(trdy_n),   64'(VEC[i].e_trdy));
      chk($sformatf("R8 vec%0d stop", i),   64'(stop_n),   64'(VEC[i].e_stop));
      chk($sformatf("R4 vec%0d hit", i),    64'(bar_hit),  64'(VEC[i].e_hit));
      chk($sformatf("R1 vec%0d cmd", i),    64'(cmd_out),  64'(VEC[i].e_cmd));
      lcl_ready = 1'b1;
      finish_txn();
    end

    // R2 timing, R9 narrow burst read from the lower DWORD, R10 turnaround.
    addr_phase(4'h6, 32'h1000_0000, 1'b0, 1'b0);
    first_data(1'b1, 1'b0);
    lcl_ready = 1'b1;
    @(negedge clk);
    chk("R2 devsel high in second clock", 64'(devsel_n), 64'd1);
    @(negedge clk);
    chk("R2 devsel low in third clock", 64'(devsel_n), 64'd0);
    chk("R9 low dword first", 64'(ad_out[31:0]), 64'hCCCC_DDDD);
    chk("R9 no local strobe on low dword", 64'(lcl_xfer), 64'd0);
    chk("R9 read data driven", 64'(ad_oe), 64'd1);
    @(negedge clk);
    chk("R9 high dword second", 64'(ad_out[31:0]), 64'hAAAA_BBBB);
    chk("R9 strobe on high dword", {lcl_xfer, lcl_hi}, 64'b11);
    lcl_rdata = 64'h1111_2222_3333_4444;
    @(negedge clk);
    chk("R7 zero-wait next word low", 64'(ad_out[31:0]), 64'h3333_4444);
    frame_n = 1'b1;
    @(negedge clk);
    chk("R10 turnaround lines high", {devsel_n, trdy_n, stop_n, ack64_n, ctl_oe}, 64'b11111);
    @(negedge clk);
    chk("R10 released after one clock", 64'(ctl_oe), 64'd0);
    irdy_n = 1'b1; lcl_ready = 1'b0;
    @(negedge clk);

    // R9 start at upper DWORD: single phase strobes the local word.
    lcl_rdata = 64'hAAAA_BBBB_CCCC_DDDD;
    addr_phase(4'h6, 32'h1000_0004, 1'b0, 1'b0);
    first_data(1'b0, 1'b0);
    lcl_ready = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R9 upper dword first", 64'(ad_out[31:0]), 64'hAAAA_BBBB);
    chk("R9 single upper strobe", 64'(lcl_xfer), 64'd1);
    finish_txn();

    // R3 R9 64-bit read: full word, strobe every phase.
    addr_phase(4'h6, 32'h1000_0008, 1'b0, 1'b1);
    first_data(1'b1, 1'b1);
    lcl_ready = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R3 ack64 on wide read", 64'(ack64_n), 64'd0);
    chk("R9 wide word", ad_out, 64'hAAAA_BBBB_CCCC_DDDD);
    chk("R9 wide strobe", 64'(lcl_xfer), 64'd1);
    finish_txn();

    // R8 disconnect without data, then STOP# held until FRAME# rises.
    addr_phase(4'h7, 32'h1000_0010, 1'b0, 1'b0);
    first_data(1'b1, 1'b0);
    lcl_disc = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R8 disconnect no data", {devsel_n, trdy_n, stop_n}, 64'b010);
    @(negedge clk);
    chk("R8 stop held while frame low", {devsel_n, trdy_n, stop_n}, 64'b010);
    frame_n = 1'b1;
    @(negedge clk);
    chk("R10 turnaround after stop", {devsel_n, trdy_n, stop_n, ctl_oe}, 64'b1111);
    finish_txn();

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule